// File: doc/BRIEF.md
# Crosstalk-Legal Transition Bus Codec

This block carries a narrow data word across a wider set of physical bus signals so that every change on the bus is one that an offline analysis has judged safe from inductive coupling: not too many signals switching the same way at once, no large kick onto a quiet neighbour, and no coupling that slows a switching edge. The safe moves form a closed subgraph of bus vectors. The code walks that subgraph. The next bus vector depends on both the data word and the vector now on the bus.

The transmit side holds the present bus vector. Each valid word indexes a programmable next-vector table with the pair {present vector, data}. The receive side holds the last vector it saw. It indexes a programmable decode table with {last vector, new vector} to recover the word and a legality flag. Both tables are written through one shared address/data/write-enable port while a small controller holds the block in its programming state. This lets the same silicon be retargeted to a different package. A start vector input sets the common point that both walks begin from.

The controller has two states. PROG allows table writes and holds both state registers at the start vector. RUN encodes and decodes. The transition PROG→RUN is taken when `enable` is high at a clock edge. The transition RUN→PROG is taken when `enable` is low at a clock edge. Synchronous reset forces PROG.

Top module: `xtalk_codec`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters PROG. After that edge `bus_out` equals `start_vec`, and `rx_valid` and `code_err` are 0.
- R2: In RUN, `tx_valid` high with word d at an edge makes `bus_out` equal the encoder table entry at address {bus_out, d} after that edge. The address is N+M bits, with the present vector in the upper N bits and d in the lower M bits. Latency is one clock.
- R3: In RUN, with `tx_valid` low at an edge, `bus_out` stays the same.
- R4: In RUN, if `rx_bus` differs from the stored last vector at an edge, then after that edge `rx_valid` equals bit M of the decoder entry at address {last, rx_bus}, and `rx_data` equals entry bits M-1:0 when that bit is 1. The address is 2N bits, with the last vector in the upper N bits. The stored last vector then becomes `rx_bus`.
- R5: In RUN, an `rx_bus` equal to the stored last vector gives no strobe and no error, whatever that table entry holds.
- R6: A changed `rx_bus` whose decoder entry has bit M clear sets `code_err` with no strobe. `code_err` stays set until reset.
- R7: `tbl_we` writes `tbl_wdata` at `tbl_addr` into the encoder table when `tbl_sel`=0, or into the decoder table when `tbl_sel`=1 (low M+1 bits), only in PROG. Writes issued in RUN have no effect.
- R8: After a RUN→PROG transition, `bus_out` returns to `start_vec` one edge later and `rx_valid` stays 0. The next RUN begins both walks from `start_vec`.
- R9: Reprogramming the tables in PROG changes the mapping, so the same present vector and data can produce a different next vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | 1 requests RUN, 0 requests PROG |
| start_vec | input | N_SIG | Common starting bus vector (must lie in the closed set) |
| tbl_we | input | 1 | Table write strobe (effective in PROG only) |
| tbl_sel | input | 1 | 0 selects the encoder table, 1 the decoder table |
| tbl_addr | input | 2*N_SIG | Table write address |
| tbl_wdata | input | N_SIG | Table write data |
| tx_valid | input | 1 | Data word present this cycle |
| tx_data | input | M_DAT | Data word to send |
| bus_out | output | N_SIG | Encoded physical bus vector |
| rx_bus | input | N_SIG | Received physical bus vector |
| rx_valid | output | 1 | Decoded word strobe |
| rx_data | output | M_DAT | Decoded word |
| code_err | output | 1 | Sticky illegal-transition flag |

## Verification
The bench loops the bus back and drives a walk whose next vector depends on the present vector. An encoder that ignored its own state would therefore emit the wrong vectors. Idle cycles are run against a decoder table whose self-edge entries are marked illegal: a decoder that consulted the table on an unchanged vector would raise `code_err`. Table writes are attempted during RUN to catch a missing write gate. An illegal transition is injected and then followed by a legal one to expose a flag that is not sticky or a strobe raised on the error. Leaving RUN with a new start vector, and reprogramming a second code, catch state registers that fail to resynchronise.

// File: rtl/xtc_pkg.sv
package xtc_pkg;
    typedef enum logic {
        MODE_PROG = 1'b0,
        MODE_RUN  = 1'b1
    } xtc_mode_e;
endpackage

// File: rtl/xtc_ctrl.sv
module xtc_ctrl
    import xtc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic run,
    output logic prog_ok
);
    xtc_mode_e mode_q, mode_d;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_PROG;
        else     mode_q <= mode_d;
    end

    // Transitions: PROG->RUN on enable, RUN->PROG on !enable
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_PROG: if (enable)  mode_d = MODE_RUN;
            MODE_RUN:  if (!enable) mode_d = MODE_PROG;
        endcase
    end

    always_comb begin
        unique case (mode_q)
            MODE_PROG: begin run = 1'b0; prog_ok = 1'b1; end
            MODE_RUN:  begin run = 1'b1; prog_ok = 1'b0; end
        endcase
    end
endmodule

// File: rtl/xtc_encoder.sv
module xtc_encoder #(
    parameter int N_SIG = 3,
    parameter int M_DAT = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   run,
    input  logic                   tx_valid,
    input  logic [M_DAT-1:0]       tx_data,
    input  logic [N_SIG-1:0]       start_vec,
    input  logic                   wr_en,
    input  logic [N_SIG+M_DAT-1:0] wr_addr,
    input  logic [N_SIG-1:0]       wr_data,
    output logic [N_SIG-1:0]       bus_out
);
    localparam int AW    = N_SIG + M_DAT;
    localparam int DEPTH = 1 << AW;

    logic [N_SIG-1:0] next_tbl [DEPTH];
    logic [N_SIG-1:0] cur_q;

    always_ff @(posedge clk) begin
        if (wr_en) next_tbl[wr_addr] <= wr_data;
    end

    // Present vector walks the programmed graph; idle keeps a self-edge
    always_ff @(posedge clk) begin
        if (rst || !run)   cur_q <= start_vec;
        else if (tx_valid) cur_q <= next_tbl[{cur_q, tx_data}];
    end

    assign bus_out = cur_q;
endmodule

// File: rtl/xtc_decoder.sv
module xtc_decoder #(
    parameter int N_SIG = 3,
    parameter int M_DAT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [N_SIG-1:0]   rx_bus,
    input  logic [N_SIG-1:0]   start_vec,
    input  logic               wr_en,
    input  logic [2*N_SIG-1:0] wr_addr,
    input  logic [M_DAT:0]     wr_data,
    output logic               rx_valid,
    output logic [M_DAT-1:0]   rx_data,
    output logic               code_err
);
    localparam int AW    = 2 * N_SIG;
    localparam int DEPTH = 1 << AW;

    logic [M_DAT:0]     dec_tbl [DEPTH];
    logic [N_SIG-1:0]   last_q;
    logic [M_DAT:0]     entry;
    logic               moved;

    always_ff @(posedge clk) begin
        if (wr_en) dec_tbl[wr_addr] <= wr_data;
    end

    assign entry = dec_tbl[{last_q, rx_bus}];
    assign moved = (last_q != rx_bus);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q   <= start_vec;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            code_err <= 1'b0;
        end else if (!run) begin
            last_q   <= start_vec;
            rx_valid <= 1'b0;
        end else begin
            last_q   <= rx_bus;
            rx_valid <= moved && entry[M_DAT];
            if (moved && entry[M_DAT])  rx_data  <= entry[M_DAT-1:0];
            if (moved && !entry[M_DAT]) code_err <= 1'b1;
        end
    end
endmodule

// File: rtl/xtalk_codec.sv
module xtalk_codec #(
    parameter int N_SIG = 3,
    parameter int M_DAT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [N_SIG-1:0]   start_vec,
    input  logic               tbl_we,
    input  logic               tbl_sel,
    input  logic [2*N_SIG-1:0] tbl_addr,
    input  logic [N_SIG-1:0]   tbl_wdata,
    input  logic               tx_valid,
    input  logic [M_DAT-1:0]   tx_data,
    output logic [N_SIG-1:0]   bus_out,
    input  logic [N_SIG-1:0]   rx_bus,
    output logic               rx_valid,
    output logic [M_DAT-1:0]   rx_data,
    output logic               code_err
);
    localparam int ENC_AW = N_SIG + M_DAT;

    logic run;
    logic prog_ok;
    logic enc_we;
    logic dec_we;

    xtc_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .run     (run),
        .prog_ok (prog_ok)
    );

    assign enc_we = tbl_we && prog_ok && !tbl_sel;
    assign dec_we = tbl_we && prog_ok &&  tbl_sel;

    xtc_encoder #(.N_SIG(N_SIG), .M_DAT(M_DAT)) u_enc (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .start_vec (start_vec),
        .wr_en     (enc_we),
        .wr_addr   (tbl_addr[ENC_AW-1:0]),
        .wr_data   (tbl_wdata),
        .bus_out   (bus_out)
    );

    xtc_decoder #(.N_SIG(N_SIG), .M_DAT(M_DAT)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .rx_bus    (rx_bus),
        .start_vec (start_vec),
        .wr_en     (dec_we),
        .wr_addr   (tbl_addr),
        .wr_data   (tbl_wdata[M_DAT:0]),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .code_err  (code_err)
    );
endmodule

// File: rtl/xtc_checker.sv
module xtc_checker #(
    parameter int N_SIG = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             tx_valid,
    input logic [N_SIG-1:0] bus_out,
    input logic [N_SIG-1:0] start_vec,
    input logic             rx_valid,
    input logic             code_err
);
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (run && !tx_valid) |=> $stable(bus_out));

    p_prog_start_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> (bus_out == $past(start_vec)));

    p_prog_no_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> !rx_valid);

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        code_err |=> code_err);

    p_err_no_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(code_err) |-> !rx_valid);
endmodule

bind xtalk_codec xtc_checker #(.N_SIG(N_SIG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .tx_valid  (tx_valid),
    .bus_out   (bus_out),
    .start_vec (start_vec),
    .rx_valid  (rx_valid),
    .code_err  (code_err)
);

// File: tb/test_xtalk_codec.sv
module test_xtalk_codec;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic [2:0] start_vec = 3'b010;
    logic       tbl_we = 1'b0;
    logic       tbl_sel = 1'b0;
    logic [5:0] tbl_addr = '0;
    logic [2:0] tbl_wdata = '0;
    logic       tx_valid = 1'b0;
    logic [1:0] tx_data = '0;
    logic [2:0] bus_out;
    logic [2:0] rx_bus;
    logic       rx_valid;
    logic [1:0] rx_data;
    logic       code_err;
    logic       loop_en = 1'b1;
    logic [2:0] rx_force = '0;

    int checks = 0;
    int errors = 0;
    int variant = 0;
    logic [2:0] exp_bus;
    logic       pend_v;
    logic [1:0] pend_d;

    always #(CLK_PERIOD/2) clk = ~clk;
    always_comb rx_bus = loop_en ? bus_out : rx_force;

    xtalk_codec i_xtalk_codec (
        .clk(clk), .rst(rst), .enable(enable), .start_vec(start_vec),
        .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .bus_out(bus_out), .rx_bus(rx_bus), .rx_valid(rx_valid),
        .rx_data(rx_data), .code_err(code_err)
    );

    function automatic logic [2:0] mask_of(int idx);
        case (idx)
            0: return 3'b001;
            1: return 3'b010;
            2: return 3'b100;
            default: return 3'b111;
        endcase
    endfunction

    function automatic logic [2:0] enc_next(logic [2:0] cur, logic [1:0] d, int v);
        int idx;
        idx = (v == 0) ? int'(d ^ cur[1:0]) : int'(d);
        return cur ^ mask_of(idx);
    endfunction

    function automatic logic [2:0] dec_entry(logic [2:0] p, logic [2:0] c, int v);
        logic [2:0] diff;
        logic [2:0] e;
        diff = p ^ c;
        e = 3'b000;
        for (int i = 0; i < 4; i++) begin
            if (mask_of(i) == diff)
                e = {1'b1, (v == 0) ? (2'(i) ^ p[1:0]) : 2'(i)};
        end
        return e;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_tbl(logic sel, logic [5:0] a, logic [2:0] d);
        tbl_we = 1'b1; tbl_sel = sel; tbl_addr = a; tbl_wdata = d;
        tick();
        tbl_we = 1'b0;
    endtask

    task automatic load_tables(int v);
        for (int a = 0; a < 32; a++)
            write_tbl(1'b0, 6'(a), enc_next(3'(a >> 2), 2'(a), v));
        for (int a = 0; a < 64; a++)
            write_tbl(1'b1, 6'(a), dec_entry(3'(a >> 3), 3'(a), v));
    endtask

    task automatic go_run();
        enable = 1'b1;
        tick();
        exp_bus = start_vec; pend_v = 1'b0; pend_d = '0;
    endtask

    task automatic send(logic v, logic [1:0] d, string req);
        tx_valid = v; tx_data = d;
        tick();
        tx_valid = 1'b0;
        if (v) exp_bus = enc_next(exp_bus, d, variant);
        chk(req, bus_out, exp_bus);
        chk("R4 strobe", rx_valid, pend_v);
        if (pend_v) chk("R4 data", rx_data, pend_d);
        pend_v = v; pend_d = d;
    endtask

    task automatic t_reset();
        repeat (3) tick();
        rst = 1'b0;
        chk("R1 bus", bus_out, 3'b010);
        chk("R1 strobe", rx_valid, 0);
        chk("R1 err", code_err, 0);
    endtask

    task automatic t_stream();
        logic [1:0] seq [8] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd0, 2'd2, 2'd1};
        for (int i = 0; i < 8; i++) send(1'b1, seq[i], "R2 encode");
        send(1'b0, 2'd0, "R3 idle");
        send(1'b0, 2'd0, "R3 idle");
        chk("R5 idle no error", code_err, 0);
    endtask

    task automatic t_write_in_run();
        logic [2:0] good;
        good = enc_next(exp_bus, 2'd1, variant);
        write_tbl(1'b0, {1'b0, exp_bus, 2'd1}, ~good);
        write_tbl(1'b1, {exp_bus, good}, 3'b000);
        send(1'b1, 2'd1, "R7 enc write ignored");
        send(1'b0, 2'd0, "R7 idle");
        chk("R7 dec write ignored", code_err, 0);
    endtask

    task automatic t_code_error();
        logic [2:0] bad;
        logic [2:0] nxt;
        logic [2:0] e;
        bad = exp_bus ^ 3'b011;
        rx_force = exp_bus; loop_en = 1'b0;
        tick();
        chk("R5 no error on hold", code_err, 0);
        rx_force = bad;
        tick();
        chk("R6 error set", code_err, 1);
        chk("R6 no strobe", rx_valid, 0);
        nxt = bad ^ 3'b001;
        rx_force = nxt;
        tick();
        e = dec_entry(bad, nxt, variant);
        chk("R6 legal after error strobe", rx_valid, 1);
        chk("R4 data after error", rx_data, e[1:0]);
        chk("R6 sticky", code_err, 1);
        loop_en = 1'b1;
        e = dec_entry(nxt, exp_bus, variant);
        pend_v = e[2]; pend_d = e[1:0];
        send(1'b0, 2'd0, "R3 idle");
    endtask

    task automatic t_return_prog();
        enable = 1'b0; start_vec = 3'b101;
        tick();
        tick();
        chk("R8 bus to start", bus_out, 3'b101);
        chk("R8 no strobe", rx_valid, 0);
        chk("R6 sticky in prog", code_err, 1);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 err cleared", code_err, 0);
        chk("R1 bus", bus_out, 3'b101);
        go_run();
        send(1'b1, 2'd2, "R8 resume from start");
        send(1'b1, 2'd0, "R8 resume from start");
        send(1'b0, 2'd0, "R3 idle");
    endtask

    task automatic t_retarget();
        enable = 1'b0;
        tick();
        tick();
        variant = 1;
        load_tables(1);
        go_run();
        chk("R9 differs", int'(enc_next(3'b101, 2'd1, 1) != enc_next(3'b101, 2'd1, 0)), 1);
        send(1'b1, 2'd1, "R9 new code");
        send(1'b1, 2'd3, "R9 new code");
        send(1'b1, 2'd0, "R9 new code");
        send(1'b0, 2'd0, "R3 idle");
        chk("R9 no error", code_err, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        load_tables(0);
        go_run();
        t_stream();
        t_write_in_run();
        t_code_error();
        t_return_prog();
        t_retarget();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule